// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-wire control link: an active-low chip select, a control clock and one shared data line. A host reaches three 8-bit registers through it: a left gain register, a right gain register and a test register. Each access is a frame of 16 control clocks. The first byte is a command or address byte and the second byte is data. For a read, chip select stays low for a second frame of 16 clocks, and the port drives the addressed register back onto the data line.

The chip-select, clock and data inputs are first brought into the system clock domain through two-flop synchronisers. Clock edges are detected after that point. Bits move most significant first. The data line has a separate output-enable, so several ports can hang on the same clock and data wires. Only the port whose chip select is low ever drives the line.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, all three registers read 00h, `sdata_oe_o` and `sdata_o` are low, and `wr_stb_o` is low.
- R2: While `cs_ni` is low, `sdata_i` is sampled on each rising control-clock edge, most significant bit first. The 16th rising edge completes the frame: bits 15..8 form the address byte and bits 7..0 form the data byte. A completed write updates the register and pulses `wr_stb_o` for one system clock.
- R3: Address bit 7 selects the direction: 0 is a write and 1 is a read. When address bits 6..2 are zero, bits 1..0 select the register: 0 = left gain, 1 = right gain, 2 = test.
- R4: A frame in which chip select rises before 16 rising edges causes no register change and no strobe.
- R5: The bit counter clears whenever chip select is high, so the next frame is decoded from its own first bit.
- R6: In a read, the addressed register is captured at the 16th rising edge. Its bits are then driven on `sdata_o` on the falling edges that start with the 16th clock's falling edge, MSB first, so the host samples them on rising edges 17 to 24. After the 8th bit, `sdata_o` is low.
- R7: `sdata_oe_o` is high from the completion of a read command until chip select goes high, and it is low at every other time.
- R8: While test register bit 1 is set, writes to both gain registers are refused and produce no strobe. The test register itself stays writable.
- R9: An address with 2 in bits 1..0 combined with nonzero bits 6..2, or with 3 in bits 1..0, selects no register. A write to such an address changes nothing and produces no strobe, and a read of it returns 00h.
- R10: Rising edges after the 16th in a write frame are ignored, and they do not change the register that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Control clock from host |
| sdata_i | input | 1 | Data line as seen at the pin |
| sdata_o | output | 1 | Reply data driven onto the line |
| sdata_oe_o | output | 1 | Tri-state enable for `sdata_o` |
| gain_l_o | output | 8 | Left gain register |
| gain_r_o | output | 8 | Right gain register |
| test_o | output | 8 | Test register |
| wr_stb_o | output | 1 | One-cycle pulse on each accepted write |

## Verification
Writes with distinct data patterns go to the left and the right register, and each register is then read back. This shows that the address decode and the bit ordering are correct in both directions. A frame cut short after 10 clocks, and a frame stretched to 20 clocks, separate a correct 16-clock framing from a counter that is off by some bits or that keeps shifting after the frame ends. Writes to unmapped addresses and writes made with the lock bit set, compared against writes made with the lock bit clear, show that the register and strobe changes come only from accepted writes.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LOCK_BIT = 1;
  typedef enum logic [1:0] {
    SEL_GAIN_L = 2'd0,
    SEL_GAIN_R = 2'd1,
    SEL_TEST   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/srp_frame.sv
module srp_frame #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sclk_s_i,
  input  logic              din_s_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] addr_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              dout_o,
  output logic              oe_o
);
  localparam int unsigned FRAME = 2 * BYTE_W;
  localparam int unsigned CNT_W = $clog2(2 * FRAME + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(2 * FRAME);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME - 1);

  logic              sclk_q;
  logic              rise, fall;
  logic [CNT_W-1:0]  cnt_q;
  logic [FRAME-1:0]  sh_q, sh_nxt;
  logic [BYTE_W-1:0] tx_q;
  logic              rd_act_q, dout_q;

  assign rise   = ~cs_n_s_i & sclk_s_i & ~sclk_q;
  assign fall   = ~cs_n_s_i & ~sclk_s_i & sclk_q;
  assign sh_nxt = {sh_q[FRAME-2:0], din_s_i};
  assign done_o = rise && (cnt_q == CNT_LAST);
  assign addr_o = sh_nxt[FRAME-1:BYTE_W];
  assign data_o = sh_nxt[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      rd_act_q <= 1'b0;
      dout_q   <= 1'b0;
    end else if (cs_n_s_i) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      rd_act_q <= 1'b0;
      dout_q   <= 1'b0;
    end else begin
      if (rise && cnt_q < CNT_MAX) begin
        sh_q  <= sh_nxt;
        cnt_q <= cnt_q + 1'b1;
      end
      if (done_o && addr_o[BYTE_W-1]) begin
        tx_q     <= rd_data_i;
        rd_act_q <= 1'b1;
      end
      if (fall && rd_act_q) begin
        dout_q <= tx_q[BYTE_W-1];
        tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign dout_o = dout_q;
  assign oe_o   = rd_act_q;

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  assert_cnt_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> cnt_q == '0);
  assert_oe_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> !oe_o);
  assert_single_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
  import srp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] gain_l_o,
  output logic [BYTE_W-1:0] gain_r_o,
  output logic [BYTE_W-1:0] test_o,
  output logic              wr_stb_o
);
  logic [BYTE_W-1:0] gain_l_q, gain_r_q, test_q;
  logic              stb_q, wr_req, accept, locked;
  reg_sel_e          sel;

  assign wr_req = done_i & ~addr_i[BYTE_W-1];
  assign locked = test_q[LOCK_BIT];

  always_comb begin
    if (addr_i[BYTE_W-2:2] != '0) sel = SEL_NONE;
    else                          sel = reg_sel_e'(addr_i[1:0]);
  end

  always_comb begin
    unique case (sel)
      SEL_GAIN_L, SEL_GAIN_R: accept = ~locked;
      SEL_TEST:               accept = 1'b1;
      default:                accept = 1'b0;
    endcase
  end

  always_comb begin
    unique case (sel)
      SEL_GAIN_L: rd_data_o = gain_l_q;
      SEL_GAIN_R: rd_data_o = gain_r_q;
      SEL_TEST:   rd_data_o = test_q;
      default:    rd_data_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_l_q <= '0;
      gain_r_q <= '0;
      test_q   <= '0;
      stb_q    <= 1'b0;
    end else begin
      stb_q <= wr_req & accept;
      if (wr_req && accept) begin
        unique case (sel)
          SEL_GAIN_L: gain_l_q <= data_i;
          SEL_GAIN_R: gain_r_q <= data_i;
          SEL_TEST:   test_q   <= data_i;
          default:    ;
        endcase
      end
    end
  end

  assign gain_l_o = gain_l_q;
  assign gain_r_o = gain_r_q;
  assign test_o   = test_q;
  assign wr_stb_o = stb_q;

  assert_gain_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(gain_l_q) && $stable(gain_r_q));
  assert_stb_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);
  assert_quiet_no_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(done_i) |-> !wr_stb_o);
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic [BYTE_W-1:0] gain_l_o,
  output logic [BYTE_W-1:0] gain_r_o,
  output logic [BYTE_W-1:0] test_o,
  output logic              wr_stb_o
);
  logic              cs_n_s, sclk_s, din_s, done;
  logic [BYTE_W-1:0] addr, data, rd_data;

  srp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdata_i}),
    .q_o   ({cs_n_s, sclk_s, din_s})
  );

  srp_frame #(.BYTE_W(BYTE_W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_s_i (cs_n_s),
    .sclk_s_i (sclk_s),
    .din_s_i  (din_s),
    .rd_data_i(rd_data),
    .done_o   (done),
    .addr_o   (addr),
    .data_o   (data),
    .dout_o   (sdata_o),
    .oe_o     (sdata_oe_o)
  );

  srp_regfile u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .addr_i   (addr),
    .data_i   (data),
    .rd_data_o(rd_data),
    .gain_l_o (gain_l_o),
    .gain_r_o (gain_r_o),
    .test_o   (test_o),
    .wr_stb_o (wr_stb_o)
  );

  assert_no_drive_deselected_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s && $past(cs_n_s) |-> !sdata_oe_o);
endmodule

// File: tb/serial_reg_port_tb_top.sv
module serial_reg_port_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic sdout, oe, stb;
  logic [7:0] gl, gr, tst;
  int checks = 0, errors = 0, stb_cnt = 0, cycles = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  serial_reg_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdata_i(sdin),
    .sdata_o(sdout), .sdata_oe_o(oe), .gain_l_o(gl), .gain_r_o(gr),
    .test_o(tst), .wr_stb_o(stb)
  );

  always @(posedge clk) if (rst_n && stb) stb_cnt++;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // n clocks; bits beyond 16 are ones; reply bits captured on clocks 17..24
  task automatic xfer(input logic [15:0] w, input int n, output logic [7:0] rd,
                      output int oe_bad);
    rd = '0;
    oe_bad = 0;
    @(negedge clk);
    cs_n = 1'b0;
    wait_n(HALF);
    for (int i = 0; i < n; i++) begin
      sdin = (i < 16) ? w[15-i] : 1'b1;
      wait_n(HALF);
      if (i >= 16 && i < 24) rd[23-i] = sdout;
      if (i >= 16 && !oe) oe_bad++;
      if (i < 16 && oe) oe_bad++;
      sclk = 1'b1;
      wait_n(HALF);
      sclk = 1'b0;
    end
    wait_n(HALF);
    cs_n = 1'b1;
    wait_n(HALF);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input int n);
    logic [7:0] rd;
    int ob;
    xfer({a, d}, n, rd, ob);
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [7:0] rd, output int ob);
    xfer({a, 8'h00}, 32, rd, ob);
  endtask

  task automatic t_reset;
    chk("R1 gain_l", gl, 0);
    chk("R1 gain_r", gr, 0);
    chk("R1 test", tst, 0);
    chk("R1 oe", oe, 0);
    chk("R1 sdata_o", sdout, 0);
  endtask

  task automatic t_write;
    int s0 = stb_cnt;
    wr(8'h00, 8'h5A, 16);
    chk("R2 gain_l write", gl, 8'h5A);
    chk("R2 one strobe", stb_cnt - s0, 1);
    wr(8'h01, 8'hC3, 16);
    chk("R3 gain_r write", gr, 8'hC3);
    chk("R3 gain_l untouched", gl, 8'h5A);
  endtask

  task automatic t_read;
    logic [7:0] rd;
    int ob, s0;
    s0 = stb_cnt;
    rdreg(8'h80, rd, ob);
    chk("R6 read left", rd, 8'h5A);
    chk("R7 oe window left", ob, 0);
    chk("R3 read gives no strobe", stb_cnt - s0, 0);
    rdreg(8'h81, rd, ob);
    chk("R6 read right", rd, 8'hC3);
    chk("R7 oe window right", ob, 0);
    chk("R7 oe low after deselect", oe, 0);
  endtask

  task automatic t_abort;
    int s0 = stb_cnt;
    wr(8'h00, 8'h11, 10);
    chk("R4 aborted no change", gl, 8'h5A);
    chk("R4 aborted no strobe", stb_cnt - s0, 0);
    wr(8'h00, 8'h22, 16);
    chk("R5 frame after abort", gl, 8'h22);
  endtask

  task automatic t_extra;
    wr(8'h01, 8'h44, 20);
    chk("R10 extra clocks ignored", gr, 8'h44);
  endtask

  task automatic t_unmapped;
    logic [7:0] rd;
    int ob, s0;
    s0 = stb_cnt;
    wr(8'h03, 8'hFF, 16);
    wr(8'h06, 8'hFF, 16);
    chk("R9 unmapped no strobe", stb_cnt - s0, 0);
    chk("R9 test untouched", tst, 0);
    chk("R9 left untouched", gl, 8'h22);
    rdreg(8'h83, rd, ob);
    chk("R9 unmapped reads zero", rd, 0);
  endtask

  task automatic t_lock;
    logic [7:0] rd;
    int ob, s0;
    wr(8'h02, 8'h02, 16);
    chk("R8 test write", tst, 8'h02);
    s0 = stb_cnt;
    wr(8'h00, 8'h99, 16);
    wr(8'h01, 8'h99, 16);
    chk("R8 locked left", gl, 8'h22);
    chk("R8 locked right", gr, 8'h44);
    chk("R8 locked no strobe", stb_cnt - s0, 0);
    rdreg(8'h82, rd, ob);
    chk("R8 read test", rd, 8'h02);
    wr(8'h02, 8'h00, 16);
    wr(8'h00, 8'h99, 16);
    chk("R8 unlocked left", gl, 8'h99);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_write();
    t_read();
    t_abort();
    t_extra();
    t_unmapped();
    t_lock();
    finish_run();
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    finish_run();
  end
endmodule